// File: doc/BRIEF.md
# JTAG Bit-Sequence Packet Executor

This block plays out a packet of JTAG bit sequences on the test pins. A packet arrives as a stream of bytes. The first byte says how many sequences follow. Each sequence is a header byte followed by its TDI payload. The header carries three things: whether TDO should be returned, the TMS level to hold for every bit of the sequence, and a bit length. The block drives TCK, TMS and TDI and samples TDO. Captured TDO bits go back on a byte stream, after a leading status byte.

Both byte interfaces are valid/ready. A byte moves on a clock edge where valid and ready are both high. The input is held off while TCK is pulsing: a new header or payload byte is taken only after the last TCK cycle of the byte in flight has completed. The output holds valid and data steady until the consumer raises ready, and the block waits rather than drop a captured byte. TCK speed is set by the plain `half_period` input. Change it only while the block is idle between packets. TMS comes entirely from the packet, so the block keeps no TAP state.

Top module: `jtag_seq_exec`

## Requirements
- R1: The first byte of a packet is the sequence count. A count of 0 yields only the status byte, and the block then accepts the first byte of the next packet.
- R2: The first response byte of every packet is the status code 0x00.
- R3: Header bit 7 set requests capture. A capturing sequence returns ceil(length/8) response bytes. A non-capturing sequence returns none.
- R4: Header bit 6 is the TMS level driven during every TCK pulse of that sequence.
- R5: Header bits 5..0 give the length in bits, and 0 stands for 64. Exactly that many TCK pulses are issued.
- R6: ceil(length/8) payload bytes follow the header. TDI bits are taken LSB first from each byte. Unused high bits of the last byte have no effect on TDI.
- R7: TDO is sampled at each rising TCK edge and packed LSB first. Unused high bits of a final partial response byte are 0.
- R8: Sequences run in packet order, and the responses of capturing sequences appear in that same order.
- R9: `in_ready` is low whenever TCK is high, and no byte is accepted while a payload byte is still being shifted.
- R10: Each TCK high phase lasts `half_period`+1 clock cycles, and each low phase lasts at least that long. TCK rests low when idle, and TDI and TMS do not change while TCK is high.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | DIV_W | TCK phase length minus one, in clock cycles |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte (status, then captured TDO) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
Every length from 1 to 64 is tried in a one-sequence packet. This covers full bytes, partial final bytes and the zero-means-64 encoding. Capture, TMS level, TCK divider setting and consumer stalls rotate across these runs, so a bit-count error can be told apart from a packing or TMS error. A multi-sequence packet mixes capturing and non-capturing sequences, which shows that ordering and per-sequence header handling are right. Empty and capture-free packets show that the response holds only the status byte. Payload bytes carry junk in their unused high bits, and TDO follows an arithmetic pattern indexed by pulse number, so any stray or missing pulse shifts every later comparison.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
  localparam int BYTE_W   = 8;
  localparam int LEN_W    = 6;
  localparam int MAX_BITS = 1 << LEN_W;
  localparam int CNT_W    = LEN_W + 1;
  localparam int IDX_W    = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] STATUS_OK = '0;

  typedef enum logic [2:0] {
    S_COUNT, S_STATUS, S_INFO, S_DATA, S_SHIFT, S_EMIT
  } seq_state_e;

  typedef struct packed {
    logic             capture;
    logic             tms_lvl;
    logic [CNT_W-1:0] nbits;
  } seq_hdr_t;

  // capture flag in bit 7, TMS level in bit 6, length in bits 5..0 (0 = 64)
  function automatic seq_hdr_t decode_hdr(input logic [BYTE_W-1:0] b);
    seq_hdr_t h;
    h.capture = b[BYTE_W-1];
    h.tms_lvl = b[BYTE_W-2];
    h.nbits   = (b[LEN_W-1:0] == '0) ? CNT_W'(MAX_BITS) : {1'b0, b[LEN_W-1:0]};
    return h;
  endfunction
endpackage

// File: rtl/jseq_tck_gen.sv
module jseq_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             tck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             phase_end;

  assign phase_end = run && (cnt == half_period);
  assign rise      = phase_end && !tck;
  assign fall      = phase_end && tck;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jseq_bit_engine.sv
module jseq_bit_engine
  import jseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              rise,
  input  logic              fall,
  input  logic              tdo,
  output logic              tdi,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              byte_done
);
  logic [BYTE_W-1:0] sh;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last;

  assign tdi       = sh[0];
  assign byte_done = fall && (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      idx      <= '0;
      last     <= '0;
      cap_byte <= '0;
    end else if (load) begin
      sh       <= load_data;
      idx      <= '0;
      last     <= last_idx;
      cap_byte <= '0;
    end else begin
      if (rise) cap_byte[idx] <= tdo;
      if (fall) begin
        sh  <= sh >> 1;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/jtag_seq_exec.sv
module jtag_seq_exec
  import jseq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  seq_state_e        st;
  logic [BYTE_W-1:0] seq_left;
  logic [CNT_W-1:0]  bits_left;
  logic [CNT_W-1:0]  chunk;
  logic              cap_en;
  logic              tms_q;
  logic              in_fire, out_fire;
  logic              rise, fall, byte_done, run;
  logic [BYTE_W-1:0] cap_byte;
  seq_hdr_t          hdr;

  assign hdr      = decode_hdr(in_data);
  assign chunk    = (bits_left >= CNT_W'(BYTE_W)) ? CNT_W'(BYTE_W) : bits_left;
  assign in_ready = (st == S_COUNT) || (st == S_DATA) ||
                    ((st == S_INFO) && (seq_left != '0));
  assign out_valid = (st == S_STATUS) || (st == S_EMIT);
  assign out_data  = (st == S_EMIT) ? cap_byte : STATUS_OK;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign run       = (st == S_SHIFT);
  assign tms       = tms_q;

  jseq_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk(clk), .rst_n(rst_n), .run(run), .half_period(half_period),
    .tck(tck), .rise(rise), .fall(fall)
  );

  jseq_bit_engine u_bits (
    .clk(clk), .rst_n(rst_n),
    .load((st == S_DATA) && in_fire), .load_data(in_data),
    .last_idx(IDX_W'(chunk - 1'b1)),
    .rise(rise), .fall(fall), .tdo(tdo),
    .tdi(tdi), .cap_byte(cap_byte), .byte_done(byte_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_COUNT;
      seq_left  <= '0;
      bits_left <= '0;
      cap_en    <= 1'b0;
      tms_q     <= 1'b0;
    end else begin
      case (st)
        S_COUNT: if (in_fire) begin
          seq_left <= in_data;
          st       <= S_STATUS;
        end
        S_STATUS: if (out_fire) st <= S_INFO;
        S_INFO: begin
          if (seq_left == '0) begin
            st <= S_COUNT;
          end else if (in_fire) begin
            cap_en    <= hdr.capture;
            tms_q     <= hdr.tms_lvl;
            bits_left <= hdr.nbits;
            seq_left  <= seq_left - 1'b1;
            st        <= S_DATA;
          end
        end
        S_DATA: if (in_fire) begin
          bits_left <= bits_left - chunk;
          st        <= S_SHIFT;
        end
        S_SHIFT: if (byte_done) begin
          if (cap_en)                 st <= S_EMIT;
          else if (bits_left == '0)   st <= S_INFO;
          else                        st <= S_DATA;
        end
        S_EMIT: if (out_fire) st <= (bits_left == '0) ? S_INFO : S_DATA;
        default: st <= S_COUNT;
      endcase
    end
  end
endmodule

// File: rtl/jseq_exec_checker.sv
module jseq_exec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       tck,
  input logic       tms,
  input logic       tdi
);
  assert_no_input_while_clocking_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> !in_ready);

  assert_tck_low_while_responding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !tck);

  assert_pins_steady_high_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tck |=> (!tck || ($stable(tdi) && $stable(tms))));

  assert_response_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_one_side_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind jtag_seq_exec jseq_exec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/jtag_seq_exec_bench.sv
module jtag_seq_exec_bench;
  localparam int DIV_W = 4;
  localparam int NB = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DIV_W-1:0] half_period = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic tck, tms, tdi;
  logic tdo = 1'b0;

  jtag_seq_exec #(.DIV_W(DIV_W)) u_jtag_seq_exec (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int n_chk = 0, n_fail = 0;
  logic exp_tdi [NB], exp_tms [NB], got_tdi [NB], got_tms [NB];
  logic [7:0] exp_resp [256], got_resp [256], pkt [1024];
  int gb = 0, tot_rise = 0, tk = 0, n_pkt = 0, n_exp = 0, n_resp = 0, seqid = 0;
  bit stress = 0;
  int hold_bad = 0, rdy_bad = 0, hi_bad = 0, lo_bad = 0;

  function automatic logic fbit(input int k);
    return ((k * 37 + (k >> 3)) % 5) < 2;
  endfunction

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // target model: TDO advances on each falling TCK, so rise k sees fbit(k)
  always @(negedge tck) begin
    tk = tk + 1;
    tdo = fbit(tk);
  end

  always @(posedge tck) begin
    if (tot_rise < NB) begin
      got_tdi[tot_rise] = tdi;
      got_tms[tot_rise] = tms;
    end
    tot_rise = tot_rise + 1;
  end

  // response consumer with optional stalls, plus pin-timing monitors
  initial begin
    int rc = 0;
    bit pend = 0;
    logic [7:0] pd = '0;
    int hi = 0, lo = 0;
    forever begin
      @(negedge clk);
      out_ready = stress ? (rc % 3 != 0) : 1'b1;
      rc++;
      #1;
      if (pend && !(out_valid && out_data == pd)) hold_bad++;
      pend = out_valid && !out_ready;
      pd = out_data;
      if (out_valid && out_ready) begin
        if (n_resp < 256) got_resp[n_resp] = out_data;
        n_resp++;
      end
      if (tck && in_ready) rdy_bad++;
      if (tck) begin
        if (lo != 0 && lo < int'(half_period) + 1) lo_bad++;
        lo = 0;
        hi++;
      end else begin
        if (hi != 0 && hi != int'(half_period) + 1) hi_bad++;
        hi = 0;
        lo++;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  int base;
  task automatic start_pkt();
    n_pkt = 1;
    pkt[0] = 8'd0;
    exp_resp[0] = 8'h00;
    n_exp = 1;
    base = gb;
  endtask

  task automatic add_seq(input bit cap, input bit tmsl, input int len);
    int nb = (len + 7) / 8;
    logic [7:0] db, rb;
    pkt[n_pkt] = {cap, tmsl, 6'(len % 64)};
    n_pkt = n_pkt + 1;
    pkt[0] = pkt[0] + 8'd1;
    for (int j = 0; j < nb; j++) begin
      db = 8'((seqid * 53 + j * 29 + 165) & 255);
      pkt[n_pkt] = db;
      n_pkt = n_pkt + 1;
      rb = '0;
      for (int b = 0; b < 8; b++) begin
        if (j * 8 + b < len) begin
          exp_tdi[gb] = db[b];
          exp_tms[gb] = tmsl;
          if (cap) rb[b] = fbit(gb);
          gb = gb + 1;
        end
      end
      if (cap) begin
        exp_resp[n_exp] = rb;
        n_exp = n_exp + 1;
      end
    end
    seqid++;
  endtask

  task automatic run_pkt(input string pfx, input int hp, input bit st);
    int bad_tdi = 0, bad_tms = 0, bad_resp = 0;
    half_period = DIV_W'(hp);
    stress = st;
    n_resp = 0;
    for (int i = 0; i < n_pkt; i++) send_byte(pkt[i]);
    while (n_resp < n_exp) @(negedge clk);
    repeat (4 * (hp + 1) + 20) @(negedge clk);
    #1;
    chk({pfx, " R2 status byte"}, got_resp[0] == 8'h00, got_resp[0], 0);
    chk({pfx, " R3 response count"}, n_resp == n_exp, n_resp, n_exp);
    for (int i = 1; i < n_exp && i < n_resp; i++)
      if (got_resp[i] !== exp_resp[i]) bad_resp++;
    chk({pfx, " R7 captured bytes mismatched"}, bad_resp == 0, bad_resp, 0);
    chk({pfx, " R5 TCK pulse total"}, tot_rise == gb, tot_rise, gb);
    for (int i = base; i < gb && i < NB; i++) begin
      if (got_tdi[i] !== exp_tdi[i]) bad_tdi++;
      if (got_tms[i] !== exp_tms[i]) bad_tms++;
    end
    chk({pfx, " R6 TDI bits mismatched"}, bad_tdi == 0, bad_tdi, 0);
    chk({pfx, " R4 TMS bits mismatched"}, bad_tms == 0, bad_tms, 0);
    chk({pfx, " R10 TCK idle low"}, tck == 1'b0, tck, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 reset tck", tck == 1'b0, tck, 0);
    chk("R11 reset out_valid", out_valid == 1'b0, out_valid, 0);
    chk("R1 reset in_ready", in_ready == 1'b1, in_ready, 1);

    // R1: empty packet
    start_pkt();
    run_pkt("R1 empty", 0, 0);
    chk("R1 ready for next packet", in_ready == 1'b1, in_ready, 1);

    // R3: two non-capturing sequences give only the status byte
    start_pkt();
    add_seq(0, 1, 3);
    add_seq(0, 0, 17);
    run_pkt("R3 no-capture", 1, 1);

    // single-sequence sweep over every length, 64 encoded as 0 (R5)
    for (int len = 1; len <= 64; len++) begin
      start_pkt();
      add_seq(len % 3 != 0, len[0] ^ len[2], len);
      run_pkt($sformatf("len%0d", len), len % 3, len[1]);
    end

    // R8: mixed multi-sequence packet
    start_pkt();
    add_seq(1, 0, 5);
    add_seq(0, 1, 12);
    add_seq(1, 1, 64);
    add_seq(1, 0, 9);
    run_pkt("R8 multi", 2, 1);

    chk("R9 in_ready high with TCK high", rdy_bad == 0, rdy_bad, 0);
    chk("R10 TCK high phase width errors", hi_bad == 0, hi_bad, 0);
    chk("R10 TCK low phase too short", lo_bad == 0, lo_bad, 0);
    chk("R11 stalled response changed", hold_bad == 0, hold_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule